// File: doc/BRIEF.md
# Predicated Dispatch Conflict Resolver

This block sits at the dispatch stage of a statically scheduled, wide-issue pipeline. The compiler may place several guarded operations on the same functional unit in one issue bundle, on the bet that their guards are rarely true together. Each cycle the resolver accepts a bundle in which every slot has a valid bit, a target unit id and a predicate register index. It reads the guard values at dispatch and nullifies every operation whose guard is false. Only the surviving operations compete for the units.

When no unit is wanted by more than one surviving operation, the bundle issues in a single cycle. When a unit is contended, the survivors drain over several cycles. Each unit accepts at most one operation per cycle, and the contending operations go in ascending slot order. During the drain the resolver holds a stall towards the fetch, decode and register-read stages. A parameter adds a detection-and-recovery latency of 0 or 1 cycle to every conflicting bundle. A wrapping counter records every cycle the upstream stages are stalled.

Top module: `pred_dispatch_resolver`

## Requirements
- R1: A slot is live when three things hold: its valid bit is set, its guard reads true, and its unit id is below UNITS. Predicate index 0 always reads true whatever `pred_file[0]` holds. For index i > 0 the guard is `pred_file[i]`. Slot s uses `bnd_unit[s*UID_W +: UID_W]` and `bnd_preg[s*PIDX_W +: PIDX_W]`.
- R2: An operation that is not live never appears on any unit's issue port.
- R3: A bundle in which every unit has at most one live operation is accepted at a clock edge. In the following cycle, `iss_valid[u]` is set and `iss_slot[u*SLOT_W +: SLOT_W]` names the slot for every unit u that has a live operation, and `stall_up` stays low.
- R4: Each unit issues at most one operation per cycle. Operations sharing a unit issue in ascending slot order, one per drain cycle. Different units issue in the same cycle. Every live operation issues exactly once.
- R5: With LATENCY = 1, a conflicting bundle (some unit with two or more live operations) spends its first cycle after acceptance with no issue, then drains.
- R6: For a conflicting bundle, `stall_up` is high for LATENCY + dispatch_cycles − 1 consecutive cycles. Here dispatch_cycles is the largest live count on any one unit. A new bundle is accepted only at an edge where `stall_up` is low; bundle inputs seen while it is high are ignored.
- R7: `conflict_cnt` increases by one for every cycle in which `stall_up` is high, holds otherwise, and wraps at 2^CNT_W.
- R8: Reset clears the pending bundle and the counter. After reset, `stall_up` is low, no unit issues and `conflict_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with clk |
| bnd_valid | input | SLOTS | Per-slot valid bit of the offered bundle |
| bnd_unit | input | SLOTS*UID_W | Per-slot target unit id |
| bnd_preg | input | SLOTS*PIDX_W | Per-slot guard predicate index |
| pred_file | input | PREGS | Current predicate register values |
| stall_up | output | 1 | Holds fetch, decode and register read; bundle not accepted |
| iss_valid | output | UNITS | Unit u receives an operation this cycle |
| iss_slot | output | UNITS*SLOT_W | Slot index issued to each unit |
| conflict_cnt | output | CNT_W | Count of conflict stall cycles |

## Verification
The assertions assume that upstream offers a new bundle only when `stall_up` is low. They also assume that reset is released away from the clock edge, so the first checked cycle starts from an empty pending state. The stimulus presents each bundle for exactly one cycle and then lets the resolver drain to idle before it offers the next one. Every unit-id combination, including the out-of-range id 3, is swept against every valid mask and every guard pattern. Two resolvers, one per latency setting, see the same bundles, so the bubble cycle and the stall lengths are compared against the arithmetic model at both latencies.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  // Index width for a set of n items, at least one bit.
  function automatic int pdr_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pdr_guard_eval.sv
module pdr_guard_eval
  import pdr_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int UNITS  = 3,
  parameter int PREGS  = 4,
  localparam int UID_W  = pdr_w(UNITS),
  localparam int PIDX_W = pdr_w(PREGS)
) (
  input  logic [SLOTS-1:0]        valid,
  input  logic [SLOTS*UID_W-1:0]  unit_ids,
  input  logic [SLOTS*PIDX_W-1:0] preg_ids,
  input  logic [PREGS-1:0]        pred_file,
  output logic [SLOTS-1:0]        live
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [UID_W-1:0]  uid;
    logic [PIDX_W-1:0] pid;
    logic              guard;
    logic              in_range;
    assign uid      = unit_ids[s*UID_W +: UID_W];
    assign pid      = preg_ids[s*PIDX_W +: PIDX_W];
    // index zero is the hardwired true predicate
    assign guard    = (pid == '0) ? 1'b1
                    : ((int'(pid) < PREGS) ? pred_file[pid] : 1'b0);
    assign in_range = (int'(uid) < UNITS);
    assign live[s]  = valid[s] & guard & in_range;
  end
endmodule

// File: rtl/pdr_unit_pick.sv
module pdr_unit_pick
  import pdr_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int UNITS   = 3,
  parameter int UNIT_ID = 0,
  localparam int UID_W  = pdr_w(UNITS),
  localparam int SLOT_W = pdr_w(SLOTS),
  localparam int CNT_W  = pdr_w(SLOTS + 1) + 1
) (
  input  logic [SLOTS-1:0]       pend,
  input  logic [SLOTS*UID_W-1:0] unit_ids,
  output logic [SLOTS-1:0]       grant,
  output logic                   gvalid,
  output logic [SLOT_W-1:0]      gslot,
  output logic                   multi
);
  logic [CNT_W-1:0] claim_cnt;

  always_comb begin
    gvalid    = 1'b0;
    gslot     = '0;
    claim_cnt = '0;
    // descending scan leaves the lowest matching slot selected
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (pend[s] && (unit_ids[s*UID_W +: UID_W] == UID_W'(UNIT_ID))) begin
        gvalid    = 1'b1;
        gslot     = SLOT_W'(s);
        claim_cnt = claim_cnt + 1'b1;
      end
    end
    grant = '0;
    if (gvalid) grant[gslot] = 1'b1;
    multi = (claim_cnt > CNT_W'(1));
  end
endmodule

// File: rtl/pdr_stall_count.sv
module pdr_stall_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt_d;
  end
endmodule

// File: rtl/pred_dispatch_resolver.sv
module pred_dispatch_resolver
  import pdr_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int UNITS   = 3,
  parameter int PREGS   = 4,
  parameter int CNT_W   = 16,
  parameter int LATENCY = 1,
  localparam int UID_W  = pdr_w(UNITS),
  localparam int SLOT_W = pdr_w(SLOTS),
  localparam int PIDX_W = pdr_w(PREGS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         bnd_valid,
  input  logic [SLOTS*UID_W-1:0]   bnd_unit,
  input  logic [SLOTS*PIDX_W-1:0]  bnd_preg,
  input  logic [PREGS-1:0]         pred_file,
  output logic                     stall_up,
  output logic [UNITS-1:0]         iss_valid,
  output logic [UNITS*SLOT_W-1:0]  iss_slot,
  output logic [CNT_W-1:0]         conflict_cnt
);
  // ---------------- guard evaluation at dispatch ----------------
  logic [SLOTS-1:0] live_in;

  pdr_guard_eval #(.SLOTS(SLOTS), .UNITS(UNITS), .PREGS(PREGS)) u_guard (
    .valid     (bnd_valid),
    .unit_ids  (bnd_unit),
    .preg_ids  (bnd_preg),
    .pred_file (pred_file),
    .live      (live_in)
  );

  // ---------------- held bundle state ----------------
  logic [SLOTS-1:0]       pend_q, pend_d;
  logic [SLOTS*UID_W-1:0] unit_q;
  logic                   fresh_q, fresh_d;
  logic                   accept;

  // ---------------- per-unit selection ----------------
  logic [SLOTS-1:0] grant_u [UNITS];
  logic [UNITS-1:0] gvalid_u;
  logic [UNITS-1:0] multi_u;
  logic [SLOT_W-1:0] gslot_u [UNITS];

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    pdr_unit_pick #(.SLOTS(SLOTS), .UNITS(UNITS), .UNIT_ID(u)) u_pick (
      .pend     (pend_q),
      .unit_ids (unit_q),
      .grant    (grant_u[u]),
      .gvalid   (gvalid_u[u]),
      .gslot    (gslot_u[u]),
      .multi    (multi_u[u])
    );
  end

  logic             conflict;
  logic             bubble;
  logic [SLOTS-1:0] issued;
  logic [SLOTS-1:0] left_after;

  assign conflict = |multi_u;

  if (LATENCY == 1) begin : g_lat_one
    assign bubble = fresh_q & conflict;
  end else begin : g_lat_zero
    assign bubble = 1'b0;
  end

  always_comb begin
    issued = '0;
    for (int u = 0; u < UNITS; u++) begin
      if (!bubble) issued = issued | grant_u[u];
    end
  end

  always_comb begin
    iss_slot = '0;
    for (int u = 0; u < UNITS; u++) begin
      iss_valid[u] = gvalid_u[u] & ~bubble;
      if (gvalid_u[u] && !bubble) iss_slot[u*SLOT_W +: SLOT_W] = gslot_u[u];
    end
  end

  assign left_after = pend_q & ~issued;
  assign stall_up   = bubble | (|left_after);
  assign accept     = ~stall_up;

  // ---------------- next state ----------------
  always_comb begin
    if (accept) begin
      pend_d  = live_in;
      fresh_d = 1'b1;
    end else begin
      pend_d  = left_after;
      fresh_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fresh_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      fresh_q <= fresh_d;
    end
  end

  // unit ids only load with a new bundle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unit_q <= '0;
    else if (accept) unit_q <= bnd_unit;
  end

  // ---------------- conflict stall counter ----------------
  pdr_stall_count #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (stall_up),
    .cnt   (conflict_cnt)
  );
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
  parameter int SLOTS   = 4,
  parameter int UNITS   = 3,
  parameter int CNT_W   = 16,
  parameter int LATENCY = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall_up,
  input logic [UNITS-1:0] iss_valid,
  input logic [CNT_W-1:0] conflict_cnt,
  input logic [SLOTS-1:0] pend_q,
  input logic [SLOTS-1:0] issued
);
  // R7: counter holds when not stalled
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_up |=> conflict_cnt == $past(conflict_cnt));

  // R7: counter advances once per stall cycle
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |=> conflict_cnt == CNT_W'($past(conflict_cnt) + 1'b1));

  // R6: a stall always has held operations behind it
  p_stall_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |-> pend_q != '0);

  // R4: one issue port per issued slot
  p_one_port_per_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(issued) == $countones(iss_valid));

  // R2: issued slots are always held operations
  p_issue_from_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issued & ~pend_q) == '0);

  if (LATENCY == 1) begin : g_bubble
    // R5: first stalled cycle of a conflicting bundle issues nothing
    p_bubble_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stall_up) |-> iss_valid == '0);
  end
endmodule

bind pred_dispatch_resolver pdr_checker #(
  .SLOTS(SLOTS), .UNITS(UNITS), .CNT_W(CNT_W), .LATENCY(LATENCY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall_up     (stall_up),
  .iss_valid    (iss_valid),
  .conflict_cnt (conflict_cnt),
  .pend_q       (pend_q),
  .issued       (issued)
);

// File: tb/tb_pred_dispatch_resolver.sv
module tb_pred_dispatch_resolver;
  localparam int SLOTS = 4;
  localparam int UNITS = 3;
  localparam int PREGS = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic       rst_n;
  logic [3:0] bv;
  logic [7:0] bu;
  logic [7:0] bp;
  logic [3:0] pf;

  logic        st1, st0;
  logic [2:0]  iv1, iv0;
  logic [5:0]  is1, is0;
  logic [15:0] c1, c0;

  pred_dispatch_resolver #(.SLOTS(SLOTS), .UNITS(UNITS), .PREGS(PREGS),
                           .CNT_W(CNT_W), .LATENCY(1)) dut (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bv), .bnd_unit(bu), .bnd_preg(bp),
    .pred_file(pf), .stall_up(st1), .iss_valid(iv1), .iss_slot(is1),
    .conflict_cnt(c1));

  pred_dispatch_resolver #(.SLOTS(SLOTS), .UNITS(UNITS), .PREGS(PREGS),
                           .CNT_W(CNT_W), .LATENCY(0)) dut_l0 (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bv), .bnd_unit(bu), .bnd_preg(bp),
    .pred_file(pf), .stall_up(st0), .iss_valid(iv0), .iss_slot(is0),
    .conflict_cnt(c0));

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Live mask from R1
  function automatic logic [3:0] live_of(input logic [3:0] v, input logic [7:0] u,
                                         input logic [7:0] p, input logic [3:0] f);
    logic [3:0] l;
    for (int s = 0; s < 4; s++) begin
      int ui = int'(u[s*2 +: 2]);
      int pi = int'(p[s*2 +: 2]);
      bit g  = (pi == 0) || f[pi];
      l[s] = v[s] && g && (ui < UNITS);
    end
    return l;
  endfunction

  function automatic int max_claims(input logic [3:0] l, input logic [7:0] u);
    int m = 0;
    for (int un = 0; un < UNITS; un++) begin
      int n = 0;
      for (int s = 0; s < 4; s++) if (l[s] && int'(u[s*2 +: 2]) == un) n++;
      if (n > m) m = n;
    end
    return m;
  endfunction

  function automatic int total_cycles(input int lat, input logic [3:0] l, input logic [7:0] u);
    int m  = max_claims(l, u);
    int dc = (m < 1) ? 1 : m;
    int bb = (lat == 1 && m > 1) ? 1 : 0;
    return bb + dc;
  endfunction

  // {stall, iss_valid[2:0], iss_slot[5:0]} expected k cycles after acceptance
  function automatic logic [9:0] exp_word(input int lat, input int k,
                                          input logic [3:0] l, input logic [7:0] u);
    logic [9:0] w = '0;
    int m   = max_claims(l, u);
    int bb  = (lat == 1 && m > 1) ? 1 : 0;
    int tot = total_cycles(lat, l, u);
    w[9] = (k < tot - 1);
    if (k >= bb) begin
      int j = k - bb;
      for (int un = 0; un < UNITS; un++) begin
        int n = 0;
        for (int s = 0; s < 4; s++) begin
          if (l[s] && int'(u[s*2 +: 2]) == un) begin
            if (n == j) begin
              w[6 + un]    = 1'b1;
              w[un*2 +: 2] = 2'(s);
            end
            n++;
          end
        end
      end
    end
    return w;
  endfunction

  function automatic logic [9:0] act_word(input logic st, input logic [2:0] iv,
                                          input logic [5:0] is);
    logic [9:0] w;
    w = {st, iv, is};
    for (int un = 0; un < UNITS; un++) if (!iv[un]) w[un*2 +: 2] = 2'b00;
    return w;
  endfunction

  task automatic run_case(input logic [3:0] v, input logic [7:0] u,
                          input logic [7:0] p, input logic [3:0] f, input string tag);
    logic [15:0] c1s, c0s;
    logic [3:0]  l;
    int          m;
    @(negedge clk);
    bv = v; bu = u; bp = p; pf = f;
    c1s = c1; c0s = c0;
    l = live_of(v, u, p, f);
    m = max_claims(l, u);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      bv = 4'h0;   // offered for a single cycle only
      for (int lat = 0; lat < 2; lat++) begin
        logic [9:0] e = exp_word(lat, k, l, u);
        logic [9:0] a = (lat == 1) ? act_word(st1, iv1, is1) : act_word(st0, iv0, is0);
        string itag;
        if (tag != "")         itag = tag;
        else if (l != v)       itag = "R2";
        else if (m <= 1)       itag = "R3";
        else if (lat == 1 && k == 0) itag = "R5";
        else                   itag = "R4";
        chk(a[9] == e[9], "R6", $sformatf("stall lat=%0d k=%0d u=%h v=%h", lat, k, u, v),
            32'(a[9]), 32'(e[9]));
        chk(a[8:0] == e[8:0], itag, $sformatf("issue lat=%0d k=%0d u=%h v=%h f=%h", lat, k, u, v, f),
            32'(a[8:0]), 32'(e[8:0]));
      end
    end
    // R7: counter grew by the stall cycles of this bundle
    chk(c1 == 16'(c1s + 16'(total_cycles(1, l, u) - 1)), "R7", "count lat=1",
        32'(c1), 32'(16'(c1s + 16'(total_cycles(1, l, u) - 1))));
    chk(c0 == 16'(c0s + 16'(total_cycles(0, l, u) - 1)), "R7", "count lat=0",
        32'(c0), 32'(16'(c0s + 16'(total_cycles(0, l, u) - 1))));
  endtask

  initial begin
    rst_n = 1'b0; bv = '0; bu = '0; bp = '0; pf = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(st1 == 1'b0 && iv1 == '0 && c1 == '0, "R8", "reset lat=1",
        32'({st1, iv1, c1}), 32'(0));
    chk(st0 == 1'b0 && iv0 == '0 && c0 == '0, "R8", "reset lat=0",
        32'({st0, iv0, c0}), 32'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(st1 == 1'b0 && iv1 == '0 && c1 == '0, "R8", "after release",
        32'({st1, iv1, c1}), 32'(0));

    // every unit combination against every valid mask, all guards true
    for (int uu = 0; uu < 256; uu++)
      for (int vv = 0; vv < 16; vv++)
        run_case(4'(vv), 8'(uu), 8'b11_10_01_00, 4'b1111, "");

    // R1: guard patterns, pred_file[0] held false, slot 0 uses index 0
    for (int uu = 0; uu < 256; uu++)
      for (int ff = 0; ff < 8; ff++)
        run_case(4'hF, 8'(uu), 8'b11_10_01_00, {3'(ff), 1'b0}, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      if (!done && cyc > 150000) begin
        checks++;
        fails++;
        $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end
endmodule